// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block decides when a processor's local bus interface hands its bus to another master. The other master raises a hold request. The block answers with a hold acknowledge, but only at a point where a bus cycle may legally be cut. While the acknowledge is high, every bus output group is floated.

While the bus is held, the core keeps running from whatever it already has. A read request stalls it. The first write is parked in a one-entry buffer, and any further write stalls the core. When the other master gives the bus back, the parked write goes out before any new core request.

A non-maskable interrupt edge that arrives during the hold is remembered in a single bit. It is offered for service only once the bus has been returned.

Top module: `bus_hold_arbiter`

## Requirements
- R1: With `hold_req` high, `bus_active` low, `gap_kind` = 2'b00 and `gap_locked` low, `hold_ack` rises at the next rising clock edge.
- R2: While `bus_active` is high (a bus cycle or its wait states is in progress), `hold_ack` does not rise. It rises at the first edge after `bus_active` falls, provided `hold_req` is still high.
- R3: `gap_kind` codes the boundary between cycles: 2'b00 is no sequence, 2'b01 is between the two interrupt-acknowledge cycles, 2'b10 is between the repeated halves of a 16-bit-bus cycle, and 2'b11 is between the halves of a misaligned transfer. The hold is refused for 2'b01, for 2'b10, and whenever `gap_locked` is high. It is granted for 2'b00 and 2'b11 when the sequence is not locked.
- R4: While `rst_n` is low (synchronous, active low), `hold_ack` is low whatever `hold_req` does. The first edge after `rst_n` rises already honours `hold_req`.
- R5: With `hold_ack` high, a low `hold_req` makes `hold_ack` fall at the next edge.
- R6: `bus_oe` is all zeros while `hold_ack` is high and all ones otherwise. Its bit order is: 0 lock, 1 memory/IO, 2 data/control, 3 write/read, 4 address strobe, 5 address, 6 byte enables, 7 data.
- R7: While `hold_ack` is high, `core_rd_req` raises `core_stall` in the same cycle.
- R8: While `hold_ack` is high and the write buffer is empty, `core_wr_req` is accepted without stall and its address and data are captured. A write request that arrives while the buffer is full raises `core_stall`.
- R9: In the first cycle after `hold_ack` falls with a captured write, `wr_issue` is high and carries the captured address and data. In that cycle, core requests are stalled and the hold is not granted. The next cycle has `wr_issue` low.
- R10: A rising edge on `nmi_in` during the hold sets an internal latch. `nmi_pending` stays low until `hold_ack` falls and then goes high. `nmi_take` clears it.
- R11: Further `nmi_in` edges that arrive while the latch is already set are discarded, so a single `nmi_take` leaves nothing pending.
- R12: `nmi_take` has no effect while `hold_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req | input | 1 | Bus request from the other master |
| bus_active | input | 1 | A bus cycle (with wait states) is running |
| gap_kind | input | 2 | Kind of cycle boundary, coded as in R3 |
| gap_locked | input | 1 | The current sequence is locked |
| core_rd_req | input | 1 | Core wants a read cycle |
| core_wr_req | input | 1 | Core wants a write cycle |
| core_wr_addr | input | AW | Write address |
| core_wr_data | input | DW | Write data |
| core_stall | output | 1 | Core must wait |
| wr_issue | output | 1 | Buffered write is issued this cycle |
| wr_issue_addr | output | AW | Address of the issued buffered write |
| wr_issue_data | output | DW | Data of the issued buffered write |
| nmi_in | input | 1 | Non-maskable interrupt input |
| nmi_take | input | 1 | Core takes the pending interrupt |
| nmi_pending | output | 1 | Latched interrupt offered for service |
| hold_ack | output | 1 | Bus granted to the other master |
| bus_oe | output | 8 | Output-enable per bus group, order in R6 |

## Verification
The grant check assumes that the bus timing unit holds `bus_active` high for the whole cycle, including its wait states. It also assumes that `gap_kind` and `gap_locked` describe the boundary that is being crossed in that same cycle. The interrupt check assumes that `nmi_take` is never raised in the same cycle as a fresh `nmi_in` edge.

The directed stimulus changes all inputs on the falling clock edge. It keeps sequence flags steady across each grant attempt, and it never overlaps a take with a new interrupt edge. Under these conditions the assumptions hold.

// File: rtl/bha_pkg.sv
// Shared types for the bus hold arbiter.
// Assumes: gap codes are decoded only by the grant unit.
package bha_pkg;
    typedef enum logic [1:0] {
        GAP_NONE     = 2'b00,
        GAP_INTA     = 2'b01,
        GAP_HALF16   = 2'b10,
        GAP_MISALIGN = 2'b11
    } gap_kind_e;

    localparam int OE_W      = 8;
    localparam int OE_LOCK   = 0;
    localparam int OE_MIO    = 1;
    localparam int OE_DC     = 2;
    localparam int OE_WR     = 3;
    localparam int OE_STROBE = 4;
    localparam int OE_ADDR   = 5;
    localparam int OE_BE     = 6;
    localparam int OE_DATA   = 7;
endpackage

// File: rtl/bha_grant.sv
// Hold grant state: raises the acknowledge only at a legal cycle boundary
// and drops it one edge after the request goes away.
// Assumes: bus_active covers every wait state of a running cycle;
// drain_busy marks the cycle in which a buffered write goes out.
module bha_grant
    import bha_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold_req,
    input  logic      bus_active,
    input  gap_kind_e gap_kind,
    input  logic      gap_locked,
    input  logic      drain_busy,
    output logic      hold_ack
);
    logic indivisible;
    logic may_grant;

    // Boundaries inside an indivisible sequence refuse the hold.
    always_comb begin
        indivisible = gap_locked || (gap_kind == GAP_INTA) || (gap_kind == GAP_HALF16);
        may_grant   = hold_req && !bus_active && !indivisible && !drain_busy;
    end

    // Acknowledge register: enter on legal grant, leave when request drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_ack <= 1'b0;
        else if (hold_ack)
            hold_ack <= hold_req;
        else
            hold_ack <= may_grant;
    end

    assert_grant_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req && !bus_active && !gap_locked
                                  && gap_kind != GAP_INTA && gap_kind != GAP_HALF16));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack);

    assert_reset_clear_R4: assert property (@(posedge clk)
        !rst_n |=> !hold_ack);
endmodule

// File: rtl/bha_post_buf.sv
// One-entry write buffer: parks a write while the bus is held and
// presents it for one cycle once the bus comes back.
// Assumes: the core drops or changes its write request once accepted.
module bha_post_buf #(
    parameter int AW = 30,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_ack,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wb_full,
    output logic          wr_issue,
    output logic [AW-1:0] issue_addr,
    output logic [DW-1:0] issue_data
);
    logic capture;

    // Capture only into an empty buffer during the hold; issue after release.
    always_comb begin
        capture  = hold_ack && wr_req && !wb_full;
        wr_issue = wb_full && !hold_ack;
    end

    // Valid flag: set on capture, cleared by the issue cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wb_full <= 1'b0;
        else if (capture)
            wb_full <= 1'b1;
        else if (wr_issue)
            wb_full <= 1'b0;
    end

    // Payload storage, written only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_addr <= '0;
            issue_data <= '0;
        end else if (capture) begin
            issue_addr <= wr_addr;
            issue_data <= wr_data;
        end
    end

    assert_fill_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_full) |-> $past(hold_ack && wr_req));

    assert_issue_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> !wr_issue);
endmodule

// File: rtl/bha_nmi_latch.sv
// Single-bit interrupt latch: catches a rising edge and offers it only
// when the bus is not held.
// Assumes: nmi_take never coincides with a fresh edge.
module bha_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_ack,
    input  logic nmi_in,
    input  logic nmi_take,
    output logic nmi_pending
);
    logic nmi_q;
    logic nmi_rise;
    logic latched;

    // Edge detector and visible flag.
    always_comb begin
        nmi_rise    = nmi_in && !nmi_q;
        nmi_pending = latched && !hold_ack;
    end

    // Previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_q <= 1'b0;
        else
            nmi_q <= nmi_in;
    end

    // Latch: a set while already set is lost; clear only outside the hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latched <= 1'b0;
        else if (nmi_rise)
            latched <= 1'b1;
        else if (nmi_take && !hold_ack)
            latched <= 1'b0;
    end

    assert_pending_after_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nmi_pending) && !$past(nmi_rise)) |-> $fell(hold_ack));

    assert_take_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && latched) |=> latched);
endmodule

// File: rtl/bha_float.sv
// Output-enable fan-out: one enable per bus group, all off during the hold.
// Assumes: group order comes from bha_pkg.
module bha_float
    import bha_pkg::*;
(
    input  logic            hold_ack,
    output logic [OE_W-1:0] bus_oe
);
    for (genvar g = 0; g < OE_W; g++) begin : g_grp
        // Each group drives only while the bus is ours.
        always_comb bus_oe[g] = !hold_ack;
    end
endmodule

// File: rtl/bus_hold_arbiter.sv
// Top of the bus hold arbiter: combines grant, write buffer, interrupt latch
// and output floating, and decides when the core must wait.
// Assumes: core requests stay high while core_stall is high.
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int AW = 30,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_req,
    input  logic            bus_active,
    input  logic [1:0]      gap_kind,
    input  logic            gap_locked,
    input  logic            core_rd_req,
    input  logic            core_wr_req,
    input  logic [AW-1:0]   core_wr_addr,
    input  logic [DW-1:0]   core_wr_data,
    output logic            core_stall,
    output logic            wr_issue,
    output logic [AW-1:0]   wr_issue_addr,
    output logic [DW-1:0]   wr_issue_data,
    input  logic            nmi_in,
    input  logic            nmi_take,
    output logic            nmi_pending,
    output logic            hold_ack,
    output logic [OE_W-1:0] bus_oe
);
    logic wb_full;

    bha_grant u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold_req),
        .bus_active (bus_active),
        .gap_kind   (gap_kind_e'(gap_kind)),
        .gap_locked (gap_locked),
        .drain_busy (wr_issue),
        .hold_ack   (hold_ack)
    );

    bha_post_buf #(.AW(AW), .DW(DW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_ack   (hold_ack),
        .wr_req     (core_wr_req),
        .wr_addr    (core_wr_addr),
        .wr_data    (core_wr_data),
        .wb_full    (wb_full),
        .wr_issue   (wr_issue),
        .issue_addr (wr_issue_addr),
        .issue_data (wr_issue_data)
    );

    bha_nmi_latch u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_ack    (hold_ack),
        .nmi_in      (nmi_in),
        .nmi_take    (nmi_take),
        .nmi_pending (nmi_pending)
    );

    bha_float u_float (
        .hold_ack (hold_ack),
        .bus_oe   (bus_oe)
    );

    // Stall: reads and second writes in the hold, any request during drain.
    always_comb begin
        core_stall = (hold_ack && core_rd_req)
                  || (hold_ack && core_wr_req && wb_full)
                  || (wr_issue && (core_rd_req || core_wr_req));
    end

    assert_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (bus_oe == '0));

    assert_read_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && core_rd_req) |-> core_stall);

    assert_no_grant_in_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> !hold_ack);
endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
    localparam int AW = 30;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hold_req, bus_active, gap_locked;
    logic [1:0]    gap_kind;
    logic          core_rd_req, core_wr_req;
    logic [AW-1:0] core_wr_addr;
    logic [DW-1:0] core_wr_data;
    logic          core_stall, wr_issue, nmi_in, nmi_take, nmi_pending, hold_ack;
    logic [AW-1:0] wr_issue_addr;
    logic [DW-1:0] wr_issue_data;
    logic [7:0]    bus_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bus_hold_arbiter #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .bus_active(bus_active),
        .gap_kind(gap_kind), .gap_locked(gap_locked),
        .core_rd_req(core_rd_req), .core_wr_req(core_wr_req),
        .core_wr_addr(core_wr_addr), .core_wr_data(core_wr_data),
        .core_stall(core_stall), .wr_issue(wr_issue),
        .wr_issue_addr(wr_issue_addr), .wr_issue_data(wr_issue_data),
        .nmi_in(nmi_in), .nmi_take(nmi_take), .nmi_pending(nmi_pending),
        .hold_ack(hold_ack), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic take_bus();
        hold_req = 1'b1;
        step();
    endtask

    task automatic give_back();
        hold_req = 1'b0;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        hold_req = 1'b1;
        step(); step();
        chk("R4 ack low in reset", hold_ack, 0);
        chk("R6 oe on in reset", bus_oe, 8'hFF);
        chk("R10 no nmi pending after reset", nmi_pending, 0);
        rst_n = 1'b1;
        step();
        chk("R4 hold honoured right after reset", hold_ack, 1);
        give_back();
        chk("R5 ack falls after request drops", hold_ack, 0);
        chk("R6 oe restored", bus_oe, 8'hFF);
    endtask

    task automatic t_idle();
        hold_req = 1'b1;
        #1 chk("R1 no ack before edge", hold_ack, 0);
        step();
        chk("R1 ack after one edge", hold_ack, 1);
        chk("R6 all groups floated", bus_oe, 8'h00);
        give_back();
    endtask

    task automatic t_busy();
        bus_active = 1'b1;
        hold_req = 1'b1;
        step(); step(); step();
        chk("R2 no ack while cycle runs", hold_ack, 0);
        bus_active = 1'b0;
        step();
        chk("R2 ack after cycle ends", hold_ack, 1);
        give_back();
    endtask

    task automatic t_gaps();
        for (int l = 0; l < 2; l++) begin
            for (int k = 0; k < 4; k++) begin
                gap_kind = 2'(k);
                gap_locked = 1'(l);
                take_bus();
                chk($sformatf("R3 gap %0d lock %0d", k, l), hold_ack,
                    ((k == 0 || k == 3) && l == 0) ? 1 : 0);
                give_back();
                step();
            end
        end
        gap_kind = 2'b00;
        gap_locked = 1'b0;
    endtask

    task automatic t_read();
        take_bus();
        core_rd_req = 1'b1;
        #1 chk("R7 read stalls in hold", core_stall, 1);
        give_back();
        chk("R7 stall ends with hold", core_stall, 0);
        core_rd_req = 1'b0;
    endtask

    task automatic t_write();
        take_bus();
        core_wr_req = 1'b1;
        core_wr_addr = 30'h1234567;
        core_wr_data = 32'hCAFE0001;
        #1 chk("R8 first write not stalled", core_stall, 0);
        step();
        core_wr_addr = 30'h0000AB0;
        core_wr_data = 32'h5555AAAA;
        #1 chk("R8 second write stalls", core_stall, 1);
        core_wr_req = 1'b0;
        give_back();
        chk("R9 ack dropped", hold_ack, 0);
        chk("R9 issue high", wr_issue, 1);
        chk("R9 issue addr", wr_issue_addr, 30'h1234567);
        chk("R9 issue data", wr_issue_data, 32'hCAFE0001);
        core_rd_req = 1'b1;
        hold_req = 1'b1;
        #1 chk("R9 core waits behind buffered write", core_stall, 1);
        step();
        chk("R9 no grant in drain cycle", hold_ack, 0);
        chk("R9 issue one cycle", wr_issue, 0);
        core_rd_req = 1'b0;
        step();
        chk("R9 grant after drain", hold_ack, 1);
        give_back();
    endtask

    task automatic t_nmi();
        take_bus();
        nmi_in = 1'b1;
        step();
        chk("R10 nmi hidden during hold", nmi_pending, 0);
        nmi_in = 1'b0;
        nmi_take = 1'b1;
        step();
        nmi_take = 1'b0;
        nmi_in = 1'b1;
        step();
        nmi_in = 1'b0;
        give_back();
        chk("R12 take in hold did not clear", nmi_pending, 1);
        nmi_take = 1'b1;
        step();
        nmi_take = 1'b0;
        chk("R11 second edge discarded", nmi_pending, 0);
        nmi_in = 1'b1;
        step();
        chk("R10 edge outside hold pends", nmi_pending, 1);
        nmi_in = 1'b0;
        nmi_take = 1'b1;
        step();
        nmi_take = 1'b0;
        chk("R10 take clears", nmi_pending, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hold_req = 1'b0; bus_active = 1'b0; gap_kind = 2'b00;
        gap_locked = 1'b0; core_rd_req = 1'b0; core_wr_req = 1'b0;
        core_wr_addr = '0; core_wr_data = '0; nmi_in = 1'b0; nmi_take = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_busy();
        t_gaps();
        t_read();
        t_write();
        t_nmi();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule